// File: doc/BRIEF.md
# Panel Register Programming Sequencer

This block brings up a TFT panel controller with no processor in the loop. It holds three fixed command lists in an on-chip ROM: a start-up list, a power-on list and a power-off list. It plays the chosen list out over a write-only SPI link. Each list entry has three parts: the register number to address, the 16-bit value to store, and how many milliseconds to pause after the store. Every entry goes out as two 24-bit frames. The first frame selects the register and the second carries the value. The pause, if any, follows the second frame.

The host sees only plain control pins. A pulse on `boot_go` runs the start-up list. A pulse on `pwr_req` asks for the panel state given on `pwr_on`. The block records the state it last programmed, so a request that would not change that state is dropped. `busy` is high while a list is playing. `done` marks the end of each list with a one-cycle pulse. The SPI clock rate and the number of system clocks in one millisecond are both parameters.

Top module: `lcd_cmd_sequencer`

## Requirements
- R1: The register-select frame is the three bytes 0x70, 0x00 and then the entry's 8-bit register number, sent in that order.
- R2: The value frame is the three bytes 0x72, value bits 15..8 and then value bits 7..0, sent in that order.
- R3: SPI framing:
  - The link runs in SPI mode 0. `spi_sclk` idles low while `spi_cs_n` is high.
  - Data is sent MSB first. `spi_mosi` changes only while `spi_sclk` is low.
  - `spi_cs_n` stays low for exactly 24 clock pulses per frame.
- R4: The time `spi_cs_n` stays high between frames is fixed, with H = SCLK_HALF and M = CLKS_PER_MS:
  - Between the register-select frame and the value frame of one entry: exactly 2H+2 system clocks.
  - After a value frame whose pause is zero, before the next entry: exactly 2H+3 clocks.
  - After a value frame with a pause of D ms: exactly 2H+4+D·M clocks. The pause starts only after the value frame has ended.
- R5: Reset and start-up:
  - After reset, `busy` and `done` are low, `spi_cs_n` is high and `spi_sclk` is low, and nothing is sent.
  - A `boot_go` pulse taken while idle makes `busy` high after the next clock edge.
  - The start-up list is then sent: 47 entries followed by 4 entries that switch the panel to its RGB video input. The last of these writes 0x0111 to register 0x0C.
- R6: Start-up pauses:
  - Register 0x13 (value 0x0000) waits 200 ms.
  - Register 0x12 (value 0x01BB) waits 50 ms.
  - Register 0x29 waits 50 ms.
  - The final write of 0x0111 to register 0x0C waits 500 ms.
  - Every other start-up entry waits 0 ms.
- R7: The power-on list, in order:
  - register 0x10 ← 0x1280;
  - register 0x07 ← 0x0101, then wait 100 ms;
  - register 0x07 ← 0x0121;
  - register 0x07 ← 0x0123, then wait 100 ms;
  - register 0x07 ← 0x0133, then wait 10 ms.
- R8: The power-off list, in order:
  - register 0x07 ← 0x0131, then wait 100 ms;
  - register 0x07 ← 0x0130, then wait 100 ms;
  - register 0x07 ← 0x0100;
  - register 0x10 ← 0x0280;
  - register 0x12 ← 0x018B.
- R9: Recorded power state:
  - `pwr_on` = 1 requests on and 0 requests off.
  - The recorded state is off after reset and becomes on when the start-up list completes.
  - A request equal to the recorded state sends no frame, leaves `busy` low and gives no `done`.
  - Any other request runs the matching list and updates the recorded state.
- R10: Request timing and latching:
  - A request made while idle makes `busy` high after the second clock edge following it.
  - A request made while busy is held and acted on when the current list ends. A later request replaces an earlier held one.
- R11: `done` is high for exactly one cycle at the end of each list, on the same edge where `busy` falls.
- R12: A `boot_go` pulse while `busy` is high is ignored, and the list in progress is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_go | input | 1 | One-cycle pulse that runs the start-up list |
| pwr_req | input | 1 | One-cycle pulse that requests the state given on `pwr_on` |
| pwr_on | input | 1 | Requested panel state, 1 = on, 0 = off; sampled with `pwr_req` |
| busy | output | 1 | High while a list is being sent |
| done | output | 1 | One-cycle pulse at the end of each list |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data out, MSB first |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
`busy` is due one edge after `boot_go` and two edges after `pwr_req`. The bench samples it at the negative clock edge just before and just after each of those points.

On every clock, the bench rebuilds each SPI frame from the rising edges of `spi_sclk` and counts how many clocks `spi_cs_n` stays high. It compares both against a queue that holds, for each list entry, the expected 24-bit words and the expected high time under R4 (2H+2, 2H+3 or 2H+4+D·M). Each pause is therefore checked to the exact cycle.

Dropped requests are checked by watching `busy`, `done` and the bus over a window. In that window no frame may appear and `busy` must stay low.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  localparam int REG_W      = 8;
  localparam int VAL_W      = 16;
  localparam int WAIT_W     = 16;
  localparam int FRAME_BITS = 24;
  localparam int ROM_DEPTH  = 61;
  localparam int ADDR_W     = $clog2(ROM_DEPTH);

  localparam logic [7:0] SEL_PREFIX = 8'h70;
  localparam logic [7:0] VAL_PREFIX = 8'h72;

  typedef struct packed {
    logic [REG_W-1:0]  reg_no;
    logic [VAL_W-1:0]  value;
    logic [WAIT_W-1:0] wait_ms;
  } cmd_entry_t;

  localparam logic [ADDR_W-1:0] BOOT_FIRST = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] BOOT_LAST  = ADDR_W'(50);
  localparam logic [ADDR_W-1:0] ON_FIRST   = ADDR_W'(51);
  localparam logic [ADDR_W-1:0] ON_LAST    = ADDR_W'(55);
  localparam logic [ADDR_W-1:0] OFF_FIRST  = ADDR_W'(56);
  localparam logic [ADDR_W-1:0] OFF_LAST   = ADDR_W'(60);

endpackage

// File: rtl/lcd_cmd_rom.sv
module lcd_cmd_rom
  import lcd_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output cmd_entry_t        entry
);

  function automatic cmd_entry_t ent(input logic [7:0] r, input logic [15:0] v,
                                     input logic [15:0] d);
    cmd_entry_t e;
    e.reg_no  = r;
    e.value   = v;
    e.wait_ms = d;
    return e;
  endfunction

  always_comb begin
    case (addr)
      // start-up list
      6'd0:  entry = ent(8'h01, 16'h0000, 16'd0);
      6'd1:  entry = ent(8'h02, 16'h0700, 16'd0);
      6'd2:  entry = ent(8'h03, 16'h50A0, 16'd0);
      6'd3:  entry = ent(8'h04, 16'h0000, 16'd0);
      6'd4:  entry = ent(8'h08, 16'h0606, 16'd0);
      6'd5:  entry = ent(8'h09, 16'h0000, 16'd0);
      6'd6:  entry = ent(8'h0A, 16'h0000, 16'd0);
      6'd7:  entry = ent(8'h0C, 16'h0000, 16'd0);
      6'd8:  entry = ent(8'h0D, 16'h0000, 16'd0);
      6'd9:  entry = ent(8'h0F, 16'h0002, 16'd0);
      6'd10: entry = ent(8'h11, 16'h0007, 16'd0);
      6'd11: entry = ent(8'h12, 16'h0000, 16'd0);
      6'd12: entry = ent(8'h13, 16'h0000, 16'd200);
      6'd13: entry = ent(8'h07, 16'h0101, 16'd0);
      6'd14: entry = ent(8'h10, 16'h12B0, 16'd0);
      6'd15: entry = ent(8'h11, 16'h0007, 16'd0);
      6'd16: entry = ent(8'h12, 16'h01BB, 16'd50);
      6'd17: entry = ent(8'h13, 16'h0013, 16'd0);
      6'd18: entry = ent(8'h29, 16'h0010, 16'd50);
      6'd19: entry = ent(8'h30, 16'h000A, 16'd0);
      6'd20: entry = ent(8'h31, 16'h1326, 16'd0);
      6'd21: entry = ent(8'h32, 16'h0A29, 16'd0);
      6'd22: entry = ent(8'h35, 16'h0A0A, 16'd0);
      6'd23: entry = ent(8'h36, 16'h1E03, 16'd0);
      6'd24: entry = ent(8'h37, 16'h031E, 16'd0);
      6'd25: entry = ent(8'h38, 16'h0706, 16'd0);
      6'd26: entry = ent(8'h39, 16'h0303, 16'd0);
      6'd27: entry = ent(8'h3C, 16'h010E, 16'd0);
      6'd28: entry = ent(8'h3D, 16'h040E, 16'd0);
      6'd29: entry = ent(8'h50, 16'h0000, 16'd0);
      6'd30: entry = ent(8'h51, 16'h00EF, 16'd0);
      6'd31: entry = ent(8'h52, 16'h0000, 16'd0);
      6'd32: entry = ent(8'h53, 16'h013F, 16'd0);
      6'd33: entry = ent(8'h60, 16'h2700, 16'd0);
      6'd34: entry = ent(8'h61, 16'h0001, 16'd0);
      6'd35: entry = ent(8'h6A, 16'h0000, 16'd0);
      6'd36: entry = ent(8'h80, 16'h0000, 16'd0);
      6'd37: entry = ent(8'h81, 16'h0000, 16'd0);
      6'd38: entry = ent(8'h82, 16'h0000, 16'd0);
      6'd39: entry = ent(8'h83, 16'h0000, 16'd0);
      6'd40: entry = ent(8'h84, 16'h0000, 16'd0);
      6'd41: entry = ent(8'h85, 16'h0000, 16'd0);
      6'd42: entry = ent(8'h90, 16'h0010, 16'd0);
      6'd43: entry = ent(8'h92, 16'h0000, 16'd0);
      6'd44: entry = ent(8'h95, 16'h0210, 16'd0);
      6'd45: entry = ent(8'h97, 16'h0000, 16'd0);
      6'd46: entry = ent(8'h07, 16'h0133, 16'd0);
      // switch to the RGB video input
      6'd47: entry = ent(8'h03, 16'h1080, 16'd0);
      6'd48: entry = ent(8'h20, 16'h0000, 16'd0);
      6'd49: entry = ent(8'h21, 16'h0000, 16'd0);
      6'd50: entry = ent(8'h0C, 16'h0111, 16'd500);
      // power-on list
      6'd51: entry = ent(8'h10, 16'h1280, 16'd0);
      6'd52: entry = ent(8'h07, 16'h0101, 16'd100);
      6'd53: entry = ent(8'h07, 16'h0121, 16'd0);
      6'd54: entry = ent(8'h07, 16'h0123, 16'd100);
      6'd55: entry = ent(8'h07, 16'h0133, 16'd10);
      // power-off list
      6'd56: entry = ent(8'h07, 16'h0131, 16'd100);
      6'd57: entry = ent(8'h07, 16'h0130, 16'd100);
      6'd58: entry = ent(8'h07, 16'h0100, 16'd0);
      6'd59: entry = ent(8'h10, 16'h0280, 16'd0);
      6'd60: entry = ent(8'h12, 16'h018B, 16'd0);
      default: entry = ent(8'h00, 16'h0000, 16'd0);
    endcase
  end

endmodule

// File: rtl/lcd_spi_frame_tx.sv
module lcd_spi_frame_tx #(
  parameter int SCLK_HALF  = 5,
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] word,
  output logic                  ready,
  output logic                  done,
  output logic                  spi_sclk,
  output logic                  spi_mosi,
  output logic                  spi_cs_n
);

  localparam int CNT_W = $clog2(2 * SCLK_HALF + 1);
  localparam int BIT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(SCLK_HALF - 1);
  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(2 * SCLK_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_END  = BIT_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_state_t;

  tx_state_t             st;
  logic [CNT_W-1:0]      hcnt;
  logic [BIT_W-1:0]      bcnt;
  logic [FRAME_BITS-1:0] shreg;

  assign ready    = (st == TX_IDLE);
  assign spi_mosi = spi_cs_n ? 1'b0 : shreg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      hcnt     <= '0;
      bcnt     <= '0;
      shreg    <= '0;
      spi_sclk <= 1'b0;
      spi_cs_n <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        TX_IDLE: begin
          if (start) begin
            st       <= TX_SHIFT;
            shreg    <= word;
            hcnt     <= '0;
            bcnt     <= '0;
            spi_cs_n <= 1'b0;
            spi_sclk <= 1'b0;
          end
        end
        TX_SHIFT: begin
          if (hcnt == HALF_END) begin
            hcnt <= '0;
            if (!spi_sclk) begin
              spi_sclk <= 1'b1;
            end else begin
              spi_sclk <= 1'b0;
              if (bcnt == BIT_END) begin
                st       <= TX_GAP;
                spi_cs_n <= 1'b1;
              end else begin
                shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                bcnt  <= bcnt + 1'b1;
              end
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        TX_GAP: begin
          if (hcnt == GAP_END) begin
            hcnt <= '0;
            st   <= TX_IDLE;
            done <= 1'b1;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assert_sclk_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  assert_mosi_held_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sclk && $past(!spi_cs_n)) |-> $stable(spi_mosi));

  assert_deselect_before_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && $past(spi_cs_n)));

endmodule

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int CLKS_PER_MS = 100000,
  parameter int WAIT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] ms,
  output logic              busy,
  output logic              done
);

  localparam int SUB_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [SUB_W-1:0] SUB_END = SUB_W'(CLKS_PER_MS - 1);

  logic [SUB_W-1:0]  sub;
  logic [WAIT_W-1:0] left;
  logic              run;

  assign busy = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub  <= '0;
      left <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run  <= 1'b1;
        left <= ms;
        sub  <= '0;
      end else if (run) begin
        if (sub == SUB_END) begin
          sub <= '0;
          if (left == WAIT_W'(1)) begin
            left <= '0;
            run  <= 1'b0;
            done <= 1'b1;
          end else begin
            left <= left - 1'b1;
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  assert_timer_done_closes_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!run && $past(run)));

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  boot_go,
  input  logic                  pwr_req,
  input  logic                  pwr_on,
  input  cmd_entry_t            entry,
  output logic [ADDR_W-1:0]     rom_addr,
  output logic                  tx_start,
  output logic [FRAME_BITS-1:0] tx_word,
  input  logic                  tx_ready,
  input  logic                  tx_done,
  output logic                  tmr_start,
  output logic [WAIT_W-1:0]     tmr_ms,
  input  logic                  tmr_busy,
  input  logic                  tmr_done,
  output logic                  busy,
  output logic                  done
);

  typedef enum logic [2:0] {
    C_COLD, C_IDLE, C_SEL, C_SELW, C_VAL, C_VALW, C_PAUSE, C_NEXT
  } ctrl_state_t;

  ctrl_state_t       st;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] last;
  logic              boot_run;
  logic              pwr_state;
  logic              pend_vld;
  logic              pend_on;
  logic              idle_st;
  logic              consume;
  logic              has_wait;

  assign idle_st   = (st == C_COLD) || (st == C_IDLE);
  assign consume   = (st == C_IDLE) && !boot_go && pend_vld;
  assign has_wait  = (entry.wait_ms != '0);
  assign busy      = !idle_st;
  assign rom_addr  = ptr;
  assign tx_start  = (st == C_SEL) || (st == C_VAL);
  assign tmr_start = (st == C_VALW) && tx_done && has_wait;
  assign tmr_ms    = entry.wait_ms;

  always_comb begin
    if (st == C_SEL) tx_word = {SEL_PREFIX, 8'h00, entry.reg_no};
    else             tx_word = {VAL_PREFIX, entry.value};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= C_COLD;
      ptr       <= '0;
      last      <= '0;
      boot_run  <= 1'b0;
      pwr_state <= 1'b0;
      pend_vld  <= 1'b0;
      pend_on   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (pwr_req) begin
        pend_vld <= 1'b1;
        pend_on  <= pwr_on;
      end else if (consume) begin
        pend_vld <= 1'b0;
      end

      case (st)
        C_COLD, C_IDLE: begin
          if (boot_go) begin
            ptr      <= BOOT_FIRST;
            last     <= BOOT_LAST;
            boot_run <= 1'b1;
            st       <= C_SEL;
          end else if (consume && (pend_on != pwr_state)) begin
            ptr       <= pend_on ? ON_FIRST : OFF_FIRST;
            last      <= pend_on ? ON_LAST : OFF_LAST;
            boot_run  <= 1'b0;
            pwr_state <= pend_on;
            st        <= C_SEL;
          end
        end
        C_SEL:  st <= C_SELW;
        C_SELW: if (tx_done) st <= C_VAL;
        C_VAL:  st <= C_VALW;
        C_VALW: if (tx_done) st <= has_wait ? C_PAUSE : C_NEXT;
        C_PAUSE: if (tmr_done) st <= C_NEXT;
        C_NEXT: begin
          if (ptr == last) begin
            st   <= C_IDLE;
            done <= 1'b1;
            if (boot_run) pwr_state <= 1'b1;
          end else begin
            ptr <= ptr + 1'b1;
            st  <= C_SEL;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  assert_done_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_busy_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_frame_only_when_link_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> tx_ready);

  assert_pause_has_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_PAUSE) |-> (tmr_busy || tmr_done));

  assert_ignore_boot_when_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && boot_go && st != C_NEXT) |=> $stable(ptr));

endmodule

// File: rtl/lcd_cmd_sequencer.sv
module lcd_cmd_sequencer
  import lcd_seq_pkg::*;
#(
  parameter int CLKS_PER_MS = 100000,
  parameter int SCLK_HALF   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_go,
  input  logic pwr_req,
  input  logic pwr_on,
  output logic busy,
  output logic done,
  output logic spi_sclk,
  output logic spi_mosi,
  output logic spi_cs_n
);

  cmd_entry_t            entry;
  logic [ADDR_W-1:0]     rom_addr;
  logic                  tx_start;
  logic [FRAME_BITS-1:0] tx_word;
  logic                  tx_ready;
  logic                  tx_done;
  logic                  tmr_start;
  logic [WAIT_W-1:0]     tmr_ms;
  logic                  tmr_busy;
  logic                  tmr_done;

  lcd_cmd_rom u_rom (
    .addr  (rom_addr),
    .entry (entry)
  );

  lcd_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_go   (boot_go),
    .pwr_req   (pwr_req),
    .pwr_on    (pwr_on),
    .entry     (entry),
    .rom_addr  (rom_addr),
    .tx_start  (tx_start),
    .tx_word   (tx_word),
    .tx_ready  (tx_ready),
    .tx_done   (tx_done),
    .tmr_start (tmr_start),
    .tmr_ms    (tmr_ms),
    .tmr_busy  (tmr_busy),
    .tmr_done  (tmr_done),
    .busy      (busy),
    .done      (done)
  );

  lcd_spi_frame_tx #(
    .SCLK_HALF  (SCLK_HALF),
    .FRAME_BITS (FRAME_BITS)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tx_start),
    .word     (tx_word),
    .ready    (tx_ready),
    .done     (tx_done),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n)
  );

  lcd_ms_timer #(
    .CLKS_PER_MS (CLKS_PER_MS),
    .WAIT_W      (WAIT_W)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .ms    (tmr_ms),
    .busy  (tmr_busy),
    .done  (tmr_done)
  );

endmodule

// File: tb/test_lcd_cmd_sequencer.sv
module test_lcd_cmd_sequencer;

  localparam int H = 2;
  localparam int M = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_go = 1'b0;
  logic pwr_req = 1'b0;
  logic pwr_on = 1'b0;
  logic busy, done, spi_sclk, spi_mosi, spi_cs_n;

  always #5 clk = ~clk;

  lcd_cmd_sequencer #(.CLKS_PER_MS(M), .SCLK_HALF(H)) i_lcd_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .boot_go(boot_go), .pwr_req(pwr_req), .pwr_on(pwr_on),
    .busy(busy), .done(done), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  int compared = 0;
  int mismatched = 0;
  int dones = 0;
  int cyc = 0;

  int rg[61];
  int vl[61];
  int dl[61];

  logic [23:0] q_word[$];
  int          q_gap[$];
  string       q_tag[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input int k, input int r, input int v, input int d);
    rg[k] = r; vl[k] = v; dl[k] = d;
  endtask

  task automatic push_run(input int first, input int last, input string tag);
    for (int k = first; k <= last; k++) begin
      int g;
      if (k == first) g = -1;
      else if (dl[k-1] == 0) g = 2*H + 3;
      else g = 2*H + 4 + dl[k-1]*M;
      q_word.push_back({8'h70, 8'h00, 8'(rg[k])}); q_gap.push_back(g);       q_tag.push_back(tag);
      q_word.push_back({8'h72, 16'(vl[k])});       q_gap.push_back(2*H + 2); q_tag.push_back(tag);
    end
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // bus monitor and per-clock comparison
  logic        prev_cs = 1'b1, prev_sclk = 1'b0, prev_busy = 1'b0, prev_done = 1'b0;
  logic [23:0] shin = '0;
  int          nbits = 0;
  int          gapcnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      summary_and_end();
    end
    if (rst_n) begin
      check(!(spi_cs_n && spi_sclk), "R3", "sclk parked low while deselected", spi_sclk, 0);
      if (!spi_cs_n && prev_cs) begin
        nbits = 0; shin = '0;
        if (q_gap.size() > 0 && q_gap[0] >= 0)
          check(gapcnt == q_gap[0], "R4", "cs_n high clocks before frame", gapcnt, q_gap[0]);
      end
      if (!spi_cs_n && spi_sclk && !prev_sclk) begin
        shin = {shin[22:0], spi_mosi};
        nbits++;
      end
      if (spi_cs_n && !prev_cs) begin
        gapcnt = 1;
        check(nbits == 24, "R3", "clock pulses per frame", nbits, 24);
        if (q_word.size() == 0) begin
          check(1'b0, "R9", "unexpected frame", shin, 0);
        end else begin
          check(shin == q_word[0], q_tag[0], "frame word", shin, q_word[0]);
          void'(q_word.pop_front()); void'(q_gap.pop_front()); void'(q_tag.pop_front());
        end
      end else if (spi_cs_n) begin
        gapcnt++;
      end
      if (done) begin
        dones++;
        check(!busy && prev_busy, "R11", "busy falls with done", busy, 0);
        check(!prev_done, "R11", "done width one cycle", prev_done, 0);
      end
    end
    prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_busy = busy; prev_done = done;
  end

  task automatic wait_done(input int limit);
    int n = dones;
    for (int i = 0; i < limit && dones == n; i++) @(negedge clk);
    check(dones > n, "R11", "done pulse seen", dones - n, 1);
  endtask

  task automatic request(input bit on);
    @(negedge clk); pwr_req = 1'b1; pwr_on = on;
    @(negedge clk); pwr_req = 1'b0;
  endtask

  task automatic quiet_window(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!busy && !done, req, "no activity", {busy, done}, 0);
    end
  endtask

  initial begin
    put(0,'h01,'h0000,0);   put(1,'h02,'h0700,0);   put(2,'h03,'h50A0,0);
    put(3,'h04,'h0000,0);   put(4,'h08,'h0606,0);   put(5,'h09,'h0000,0);
    put(6,'h0A,'h0000,0);   put(7,'h0C,'h0000,0);   put(8,'h0D,'h0000,0);
    put(9,'h0F,'h0002,0);   put(10,'h11,'h0007,0);  put(11,'h12,'h0000,0);
    put(12,'h13,'h0000,200); put(13,'h07,'h0101,0); put(14,'h10,'h12B0,0);
    put(15,'h11,'h0007,0);  put(16,'h12,'h01BB,50); put(17,'h13,'h0013,0);
    put(18,'h29,'h0010,50); put(19,'h30,'h000A,0);  put(20,'h31,'h1326,0);
    put(21,'h32,'h0A29,0);  put(22,'h35,'h0A0A,0);  put(23,'h36,'h1E03,0);
    put(24,'h37,'h031E,0);  put(25,'h38,'h0706,0);  put(26,'h39,'h0303,0);
    put(27,'h3C,'h010E,0);  put(28,'h3D,'h040E,0);  put(29,'h50,'h0000,0);
    put(30,'h51,'h00EF,0);  put(31,'h52,'h0000,0);  put(32,'h53,'h013F,0);
    put(33,'h60,'h2700,0);  put(34,'h61,'h0001,0);  put(35,'h6A,'h0000,0);
    put(36,'h80,'h0000,0);  put(37,'h81,'h0000,0);  put(38,'h82,'h0000,0);
    put(39,'h83,'h0000,0);  put(40,'h84,'h0000,0);  put(41,'h85,'h0000,0);
    put(42,'h90,'h0010,0);  put(43,'h92,'h0000,0);  put(44,'h95,'h0210,0);
    put(45,'h97,'h0000,0);  put(46,'h07,'h0133,0);  put(47,'h03,'h1080,0);
    put(48,'h20,'h0000,0);  put(49,'h21,'h0000,0);  put(50,'h0C,'h0111,500);
    put(51,'h10,'h1280,0);  put(52,'h07,'h0101,100); put(53,'h07,'h0121,0);
    put(54,'h07,'h0123,100); put(55,'h07,'h0133,10);
    put(56,'h07,'h0131,100); put(57,'h07,'h0130,100); put(58,'h07,'h0100,0);
    put(59,'h10,'h0280,0);  put(60,'h12,'h018B,0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: reset state
    check(!busy && !done, "R5", "busy/done after reset", {busy, done}, 0);
    check(spi_cs_n && !spi_sclk, "R5", "bus idle after reset", {spi_cs_n, spi_sclk}, 2'b10);
    quiet_window(30, "R5");

    // R5, R6, R1, R2: start-up run
    push_run(0, 50, "R6");
    boot_go = 1'b1;
    @(negedge clk); boot_go = 1'b0;
    check(busy, "R5", "busy one edge after boot_go", busy, 1);
    wait_done(40000);
    check(q_word.size() == 0, "R5", "start-up frames left", q_word.size(), 0);

    // R9: state is on after start-up, so an on request is dropped
    request(1'b1);
    quiet_window(60, "R9");

    // R8, R10: off request from idle, busy after second edge
    push_run(56, 60, "R8");
    @(negedge clk); pwr_req = 1'b1; pwr_on = 1'b0;
    @(negedge clk); pwr_req = 1'b0;
    check(!busy, "R10", "busy still low one edge after request", busy, 0);
    @(negedge clk);
    check(busy, "R10", "busy two edges after request", busy, 1);
    wait_done(20000);
    check(q_word.size() == 0, "R8", "power-off frames left", q_word.size(), 0);

    // R9: second off request is dropped
    request(1'b0);
    quiet_window(60, "R9");

    // R7, R12, R10: on run; boot_go ignored; newest held request wins
    push_run(51, 55, "R7");
    request(1'b1);
    repeat (200) @(negedge clk);
    check(busy, "R12", "run in progress", busy, 1);
    boot_go = 1'b1; @(negedge clk); boot_go = 1'b0;
    request(1'b0);
    repeat (10) @(negedge clk);
    request(1'b1);
    wait_done(20000);
    check(q_word.size() == 0, "R12", "power-on frames left", q_word.size(), 0);
    quiet_window(80, "R10");

    // R10: held request runs after the current list
    push_run(56, 60, "R10");
    push_run(51, 55, "R10");
    request(1'b0);
    repeat (50) @(negedge clk);
    request(1'b1);
    wait_done(20000);
    wait_done(20000);
    check(q_word.size() == 0, "R10", "queued run frames left", q_word.size(), 0);
    quiet_window(40, "R11");

    summary_and_end();
  end

endmodule